// File: doc/BRIEF.md
# Latched-input parallel-to-serial shift register

This block turns an 8-bit parallel word into a serial bit stream through two separate storage stages. A holding latch takes a snapshot of the parallel inputs when its capture strobe rises. A shift register then either copies the latch or moves its contents one place per rising edge of a shift strobe, depending on a mode input. Because the latch has its own strobe, the next word can be captured while the current one is still leaving the shift register.

The serial output always presents the last stage of the shift register. The three-state pin is modelled as a data bit plus a drive flag. A pad wrapper can float the pin whenever the flag is low. The active-low output enable only controls the drive flag and never touches the stored state. Both strobes are sampled on the system clock, and an edge is a low sample followed by a high sample.

Top module: `piso_hold_shifter`

## Requirements
- R1: A synchronous active-high reset clears the latch, the shift register and both strobe history bits to zero. After reset `ser_out` reads 0, and a following load shows an all-zero latch.
- R2: On a detected rising edge of `cap_strobe`, the latch takes `par_in` at that clock edge. A strobe held high, or a change on `par_in` without an edge, leaves the latch unchanged.
- R3: While `shift_mode` is 0 (load mode), the shift register copies the latch on every clock. The copy uses the latch value from before that edge, so a capture made in load mode reaches the register one cycle later. `ser_in` is ignored.
- R4: While `shift_mode` is 1, a detected rising edge of `shf_strobe` shifts the register one place. `ser_in` enters bit 0 (the first stage), each bit k takes bit k-1, and bit 7 takes the old bit 6.
- R5: In shift mode with no shift-strobe edge, the shift register holds its value.
- R6: When capture and shift edges fall in the same shift-mode cycle, the latch takes the new word and the register shifts its old contents. The new word does not enter the register.
- R7: `ser_out` equals bit 7 (the last stage) of the shift register at all times. `ser_drive` is 1 exactly when `out_en_n` is 0, with no clock delay.
- R8: `out_en_n` has no effect on the latch or the shift register.
- R9: A shift-strobe edge in load mode causes no shift; the register still copies the latch.
- R10: In load mode, `par_in` reaches the register only through the latch. Without a capture edge, new values on `par_in` do not appear on the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | 8 | Parallel word, bit 0 is the first stage |
| cap_strobe | input | 1 | Latch capture strobe, rising edge acts |
| shf_strobe | input | 1 | Shift strobe, rising edge acts |
| shift_mode | input | 1 | 1 = serial shift, 0 = load from latch |
| ser_in | input | 1 | Serial data into bit 0 |
| out_en_n | input | 1 | Output enable, active low |
| ser_out | output | 1 | Last stage of the shift register |
| ser_drive | output | 1 | High when the serial pin is to be driven |

## Verification
The assertions assume that the strobes and the mode input are synchronous to the system clock and stable around each edge. They also assume that a strobe is low on the first sample after reset, since the history bits restart at zero. The stimulus changes every input on the falling clock edge, keeps both strobes low during and right after reset, and pulses each strobe for at least one cycle high and one cycle low. This keeps each edge a single clean detection.

// File: rtl/piso_hold_pkg.sv
package piso_hold_pkg;
  localparam int STROBE_COUNT = 2;
  localparam int STB_CAP = 0;
  localparam int STB_SHF = 1;

  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } stage_mode_e;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign rise = level & ~level_q;

  // a held strobe yields one detection only
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R2
endmodule

// File: rtl/hold_latch.sv
module hold_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (take) word_q <= word_in;
  end

  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    take |=> word_q == $past(word_in)); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(word_q)); // R2
endmodule

// File: rtl/stage_register.sv
module stage_register
  import piso_hold_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  stage_mode_e      mode,
  input  logic             step,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] held_word,
  output logic [WIDTH-1:0] stages_q
);
  localparam int TOP = WIDTH - 1;

  function automatic logic [WIDTH-1:0] advance(input logic [WIDTH-1:0] cur,
                                               input logic bit_in);
    return {cur[TOP-1:0], bit_in};
  endfunction

  logic [WIDTH-1:0] stages_d;

  always_comb begin
    unique case (mode)
      MODE_LOAD:  stages_d = held_word;
      MODE_SHIFT: stages_d = step ? advance(stages_q, ser_in) : stages_q;
      default:    stages_d = stages_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stages_q <= '0;
    else     stages_q <= stages_d;
  end

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LOAD) |=> stages_q == $past(held_word)); // R3
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SHIFT && step) |=>
      stages_q == {$past(stages_q[TOP-1:0]), $past(ser_in)}); // R4
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SHIFT && !step) |=> $stable(stages_q)); // R5
endmodule

// File: rtl/piso_hold_shifter.sv
module piso_hold_shifter
  import piso_hold_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_in,
  input  logic             cap_strobe,
  input  logic             shf_strobe,
  input  logic             shift_mode,
  input  logic             ser_in,
  input  logic             out_en_n,
  output logic             ser_out,
  output logic             ser_drive
);
  localparam int TOP = WIDTH - 1;

  logic [STROBE_COUNT-1:0] strobe_lvl;
  logic [STROBE_COUNT-1:0] strobe_rise;
  logic [WIDTH-1:0]        latch_word;
  logic [WIDTH-1:0]        stage_word;
  logic                    cap_edge;
  logic                    shf_edge;
  stage_mode_e             mode_sel;

  assign strobe_lvl[STB_CAP] = cap_strobe;
  assign strobe_lvl[STB_SHF] = shf_strobe;

  for (genvar i = 0; i < STROBE_COUNT; i++) begin : g_edge
    strobe_edge u_edge (
      .clk  (clk),
      .rst  (rst),
      .level(strobe_lvl[i]),
      .rise (strobe_rise[i])
    );
  end

  assign cap_edge = strobe_rise[STB_CAP];
  assign shf_edge = strobe_rise[STB_SHF];
  assign mode_sel = stage_mode_e'(shift_mode);

  hold_latch #(.WIDTH(WIDTH)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .take   (cap_edge),
    .word_in(par_in),
    .word_q (latch_word)
  );

  stage_register #(.WIDTH(WIDTH)) u_stages (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode_sel),
    .step     (shf_edge),
    .ser_in   (ser_in),
    .held_word(latch_word),
    .stages_q (stage_word)
  );

  assign ser_out   = stage_word[TOP];
  assign ser_drive = ~out_en_n;

  // the serial bit leaving must be the old next-to-last stage after a shift
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (shift_mode && shf_edge) |=> ser_out == $past(stage_word[TOP-1])); // R7
endmodule

// File: tb/sim_piso_hold_shifter.sv
module sim_piso_hold_shifter;
  localparam int T = 10;

  typedef struct packed {
    logic [7:0]  par;
    logic        cap;
    logic        shf;
    logic        mode;
    logic        ser;
    logic        oen;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VECS [NV] = '{
    '{8'hA5,1'b1,1'b0,1'b1,1'b0,1'b0,"R2"},
    '{8'h00,1'b1,1'b0,1'b1,1'b0,1'b0,"R2"},
    '{8'h3C,1'b0,1'b0,1'b1,1'b0,1'b0,"R5"},
    '{8'h3C,1'b0,1'b0,1'b0,1'b1,1'b0,"R3"},
    '{8'h3C,1'b0,1'b1,1'b0,1'b1,1'b0,"R9"},
    '{8'h3C,1'b0,1'b0,1'b1,1'b0,1'b0,"R5"},
    '{8'h00,1'b0,1'b1,1'b1,1'b1,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b1,"R8"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b1,"R8"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R7"},
    '{8'hC3,1'b1,1'b1,1'b1,1'b1,1'b0,"R6"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R6"},
    '{8'h00,1'b0,1'b1,1'b1,1'b1,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b1,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b1,"R4"},
    '{8'hFF,1'b0,1'b0,1'b0,1'b1,1'b0,"R10"},
    '{8'hFF,1'b0,1'b0,1'b1,1'b0,1'b0,"R5"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R4"},
    '{8'h5A,1'b1,1'b0,1'b0,1'b0,1'b0,"R3"},
    '{8'h5A,1'b0,1'b0,1'b0,1'b0,1'b0,"R3"},
    '{8'h00,1'b0,1'b0,1'b1,1'b1,1'b0,"R5"},
    '{8'h00,1'b0,1'b1,1'b1,1'b1,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b1,1'b0,"R4"},
    '{8'h00,1'b0,1'b1,1'b1,1'b1,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b1,1'b0,"R4"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,"R4"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b1,"R7"},
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R7"}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] par_in = '0;
  logic       cap_strobe = 1'b0;
  logic       shf_strobe = 1'b0;
  logic       shift_mode = 1'b1;
  logic       ser_in = 1'b0;
  logic       out_en_n = 1'b1;
  logic       ser_out;
  logic       ser_drive;

  int checks = 0;
  int fails = 0;

  logic [7:0] m_lat = '0;
  logic [7:0] m_sr = '0;
  logic       m_cap_q = 1'b0;
  logic       m_shf_q = 1'b0;

  always #(T/2) clk = ~clk;

  piso_hold_shifter u0 (
    .clk       (clk),
    .rst       (rst),
    .par_in    (par_in),
    .cap_strobe(cap_strobe),
    .shf_strobe(shf_strobe),
    .shift_mode(shift_mode),
    .ser_in    (ser_in),
    .out_en_n  (out_en_n),
    .ser_out   (ser_out),
    .ser_drive (ser_drive)
  );

  task automatic check(input logic [23:0] tag, input logic act, input logic exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic apply(input vec_t v);
    logic cap_e;
    logic shf_e;
    @(negedge clk);
    par_in = v.par; cap_strobe = v.cap; shf_strobe = v.shf;
    shift_mode = v.mode; ser_in = v.ser; out_en_n = v.oen;
    #1;
    check("R7", ser_drive, ~v.oen, "drive flag");
    @(posedge clk);
    cap_e = v.cap & ~m_cap_q;
    shf_e = v.shf & ~m_shf_q;
    if (!v.mode)     m_sr = m_lat;
    else if (shf_e)  m_sr = {m_sr[6:0], v.ser};
    if (cap_e)       m_lat = v.par;
    m_cap_q = v.cap;
    m_shf_q = v.shf;
    #2;
    check(v.tag, ser_out, m_sr[7], "serial bit");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cap_strobe = 1'b0; shf_strobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_lat = '0; m_sr = '0; m_cap_q = 1'b0; m_shf_q = 1'b0;
    #1;
    check("R1", ser_out, 1'b0, "after reset");
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R1: fill state with ones, reset, then load and shift out zeros
    apply('{8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0,"R1"});
    apply('{8'hFF,1'b0,1'b0,1'b0,1'b0,1'b0,"R1"});
    do_reset();
    apply('{8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,"R1"});
    for (int k = 0; k < 8; k++) begin
      apply('{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,"R1"});
      apply('{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R1"});
    end

    // R8: toggle enable every cycle during a full word, state must match
    apply('{8'h96,1'b1,1'b0,1'b0,1'b0,1'b1,"R8"});
    apply('{8'h96,1'b0,1'b0,1'b0,1'b0,1'b0,"R8"});
    for (int k = 0; k < 8; k++) begin
      apply('{8'h00,1'b0,1'b1,1'b1,1'b1,1'b1,"R8"});
      apply('{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,"R8"});
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(T * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule